// File: doc/BRIEF.md
# Predicated Vector Compare Sequencer

This block turns an integer compare-and-branch instruction word into a vector compare that fills a predicate mask. The program counter is never touched. When `start` is pulsed with a recognised instruction, the block latches the two source register numbers, the compare selector and the destination predicate index, along with the vector length `vl`. It then walks element indices 0 to vl-1 at one element per cycle. For each index it drives two register-file read addresses and compares the returned operands. It then emits a single-bit write into the chosen predicate register.

Each source is configured separately through a per-register length table. A source whose configured length is above one is stepped: element i comes from register src+i. Any other source is a scalar that is reused for every element. Greater-than and less-or-equal are not encoded; software gets them by swapping the two sources. The predicate storage lives outside the block, which only issues bit writes to it.

Top module: `pvcmp_seq`

## Requirements
- R1: A start is accepted only when instruction bits 6..0 equal 1100011. With any other value the start is ignored: no busy, no done, no illegal pulse and no predicate write follow.
- R2: Instruction bits 14..12 select the compare, with operands taken as XLEN-bit values:
  - 000 gives a==b.
  - 001 gives a!=b.
  - 100 gives a<b, signed two's complement.
  - 101 gives a>=b, signed.
  - 110 gives a<b, unsigned.
  - 111 gives a>=b, unsigned.
- R3: Selector values 010 and 011 are reserved. An accepted start carrying one raises `illegal` for exactly the one cycle after start. It writes no predicate bit and produces neither busy nor done.
- R4: Source A uses bits 19..15 and source B uses bits 24..20. A source is a vector when its entry in `reg_vlen` (VLW bits per register, register r at bits r*VLW upward) is greater than 1. A vector source reads element i from register (src+i) mod NREG. A scalar source reads register src for every element.
- R5: The result of element i is written to bit i of the predicate register named by bits 11..7. `pred_we` is high, `pred_sel` holds that index, `pred_pos` equals i, and elements are written in ascending order, one per cycle.
- R6: `busy` is high for exactly the vl effective cycles that follow the start edge. `done` pulses for one cycle in the cycle after the last write. With vl=0, `done` pulses in the cycle after start and nothing is written. After reset `busy`, `done`, `illegal` and `pred_we` are low.
- R7: No write is ever issued to a position at or above the effective vl, so those predicate bits keep their value.
- R8: Instruction bits 31..25 are ignored.
- R9: A `vl` above VLMAX is treated as VLMAX.
- R10: A start pulse while `busy` is high is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled while idle |
| instr | input | 32 | Compare instruction word |
| vl | input | VLW | Requested element count |
| reg_vlen | input | NREG*VLW | Configured length per register |
| rf_addr_a | output | REGW | Read address, source A |
| rf_data_a | input | XLEN | Read data, source A (same cycle) |
| rf_addr_b | output | REGW | Read address, source B |
| rf_data_b | input | XLEN | Read data, source B (same cycle) |
| pred_we | output | 1 | Predicate bit write strobe |
| pred_sel | output | REGW | Destination predicate register |
| pred_pos | output | POSW | Bit position being written |
| pred_val | output | 1 | Compare result for that position |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle reserved-selector flag |

## Verification
On every cycle, the assertions check the following:
- `done` and `illegal` are single-cycle pulses that never coincide with `busy`.
- Write positions stay below the latched length.
- Positions advance by one with a steady destination.
- A scalar source keeps a steady read address.

The compare truth table, signed against unsigned ordering and vector address stepping with wrap can only be shown by the bench's sweeps. The same goes for clamping of long lengths, preservation of mask bits above vl, and the cases where a start is ignored. The bench runs every operand pair of a 4-bit datapath through every selector and checks each written bit arithmetically.

// File: rtl/pvcmp_pkg.sv
package pvcmp_pkg;

   localparam logic [6:0] OPC_CMPBR = 7'b1100011;

   typedef enum logic [2:0] {
      SEL_EQ   = 3'b000,
      SEL_NE   = 3'b001,
      SEL_RSV0 = 3'b010,
      SEL_RSV1 = 3'b011,
      SEL_SLT  = 3'b100,
      SEL_SGE  = 3'b101,
      SEL_ULT  = 3'b110,
      SEL_UGE  = 3'b111
   } cmp_sel_e;

   function automatic logic sel_reserved(input cmp_sel_e s);
      return (s == SEL_RSV0) || (s == SEL_RSV1);
   endfunction

endpackage

// File: rtl/pvcmp_decode.sv
module pvcmp_decode
   import pvcmp_pkg::*;
#(
   parameter int REGW = 5
) (
   input  logic [31:0]     instr,
   output logic            is_cmp,
   output logic            legal,
   output cmp_sel_e        sel,
   output logic [REGW-1:0] src_a,
   output logic [REGW-1:0] src_b,
   output logic [REGW-1:0] dst_p
);
   logic unused_hi;

   if (REGW != 5) begin : g_bad_regw
      $error("pvcmp_decode: register fields are 5 bits wide");
   end

   assign unused_hi = ^instr[31:25];
   assign is_cmp    = (instr[6:0] == OPC_CMPBR);
   assign sel       = cmp_sel_e'(instr[14:12]);
   assign legal     = !sel_reserved(sel);
   assign src_a     = instr[19:15];
   assign src_b     = instr[24:20];
   assign dst_p     = instr[11:7];
endmodule

// File: rtl/pvcmp_opaddr.sv
module pvcmp_opaddr #(
   parameter int REGW = 5,
   parameter int POSW = 4
) (
   input  logic [REGW-1:0] src,
   input  logic            stepped,
   input  logic [POSW-1:0] idx,
   output logic [REGW-1:0] addr
);
   logic [REGW-1:0] offs;

   if (POSW > REGW) begin : g_trunc
      assign offs = idx[REGW-1:0];
   end else begin : g_ext
      assign offs = REGW'(idx);
   end

   assign addr = stepped ? (src + offs) : src;
endmodule

// File: rtl/pvcmp_cmp.sv
module pvcmp_cmp
   import pvcmp_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CMP_STYLE = 1
) (
   input  cmp_sel_e        sel,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            res
);
   logic eq, slt, ult;

   if (XLEN < 2) begin : g_bad_xlen
      $error("pvcmp_cmp: XLEN must be at least 2");
   end

   if (CMP_STYLE == 0) begin : g_direct
      assign eq  = (a == b);
      assign ult = (a < b);
      assign slt = ($signed(a) < $signed(b));
   end else begin : g_sub
      logic [XLEN:0] diff;
      logic          borrow;
      assign diff   = {1'b0, a} - {1'b0, b};
      assign borrow = diff[XLEN];
      assign eq     = (diff[XLEN-1:0] == '0);
      assign ult    = borrow;
      assign slt    = (a[XLEN-1] != b[XLEN-1]) ? a[XLEN-1] : borrow;
   end

   always_comb begin
      case (sel)
         SEL_EQ:  res = eq;
         SEL_NE:  res = !eq;
         SEL_SLT: res = slt;
         SEL_SGE: res = !slt;
         SEL_ULT: res = ult;
         SEL_UGE: res = !ult;
         default: res = 1'b0;
      endcase
   end
endmodule

// File: rtl/pvcmp_seq.sv
module pvcmp_seq
   import pvcmp_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int NREG      = 32,
   parameter int VLMAX     = 16,
   parameter int CMP_STYLE = 1,
   localparam int REGW     = $clog2(NREG),
   localparam int POSW     = $clog2(VLMAX),
   localparam int VLW      = $clog2(VLMAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [31:0]         instr,
   input  logic [VLW-1:0]      vl,
   input  logic [NREG*VLW-1:0] reg_vlen,
   output logic [REGW-1:0]     rf_addr_a,
   input  logic [XLEN-1:0]     rf_data_a,
   output logic [REGW-1:0]     rf_addr_b,
   input  logic [XLEN-1:0]     rf_data_b,
   output logic                pred_we,
   output logic [REGW-1:0]     pred_sel,
   output logic [POSW-1:0]     pred_pos,
   output logic                pred_val,
   output logic                busy,
   output logic                done,
   output logic                illegal
);
   if (NREG != 32) begin : g_bad_nreg
      $error("pvcmp_seq: NREG must be 32 to match 5-bit register fields");
   end
   if (VLMAX < 2 || (VLMAX & (VLMAX - 1)) != 0) begin : g_bad_vlmax
      $error("pvcmp_seq: VLMAX must be a power of two, at least 2");
   end
   if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_style
      $error("pvcmp_seq: CMP_STYLE must be 0 or 1");
   end

   // decode
   logic            dec_is_cmp, dec_legal;
   cmp_sel_e        dec_sel;
   logic [REGW-1:0] dec_src [2];
   logic [REGW-1:0] dec_dst;

   pvcmp_decode #(.REGW(REGW)) u_dec (
      .instr  (instr),
      .is_cmp (dec_is_cmp),
      .legal  (dec_legal),
      .sel    (dec_sel),
      .src_a  (dec_src[0]),
      .src_b  (dec_src[1]),
      .dst_p  (dec_dst)
   );

   // sequencer state
   logic            busy_q, done_q, illegal_q;
   logic [POSW-1:0] idx_q;
   logic [VLW-1:0]  vl_q;
   cmp_sel_e        sel_q;
   logic [REGW-1:0] src_q [2];
   logic            vec_q [2];
   logic [REGW-1:0] dst_q;

   logic [VLW-1:0]  vl_eff;
   logic            last_elem;
   logic            vec_now [2];
   logic [REGW-1:0] addr [2];

   assign vl_eff    = (vl > VLW'(VLMAX)) ? VLW'(VLMAX) : vl;
   assign last_elem = (VLW'(idx_q) == (vl_q - VLW'(1)));

   for (genvar gi = 0; gi < 2; gi++) begin : g_src
      assign vec_now[gi] = (reg_vlen[dec_src[gi]*VLW +: VLW] > VLW'(1));

      pvcmp_opaddr #(.REGW(REGW), .POSW(POSW)) u_addr (
         .src     (src_q[gi]),
         .stepped (vec_q[gi]),
         .idx     (idx_q),
         .addr    (addr[gi])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         idx_q     <= '0;
         vl_q      <= '0;
         sel_q     <= SEL_EQ;
         src_q[0]  <= '0;
         src_q[1]  <= '0;
         vec_q[0]  <= 1'b0;
         vec_q[1]  <= 1'b0;
         dst_q     <= '0;
      end else begin
         done_q    <= 1'b0;
         illegal_q <= 1'b0;
         if (busy_q) begin
            idx_q <= idx_q + POSW'(1);
            if (last_elem) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end else if (start && dec_is_cmp) begin
            if (!dec_legal) begin
               illegal_q <= 1'b1;
            end else begin
               idx_q    <= '0;
               vl_q     <= vl_eff;
               sel_q    <= dec_sel;
               src_q[0] <= dec_src[0];
               src_q[1] <= dec_src[1];
               vec_q[0] <= vec_now[0];
               vec_q[1] <= vec_now[1];
               dst_q    <= dec_dst;
               if (vl_eff == '0) begin
                  done_q <= 1'b1;
               end else begin
                  busy_q <= 1'b1;
               end
            end
         end
      end
   end

   pvcmp_cmp #(.XLEN(XLEN), .CMP_STYLE(CMP_STYLE)) u_cmp (
      .sel (sel_q),
      .a   (rf_data_a),
      .b   (rf_data_b),
      .res (pred_val)
   );

   assign rf_addr_a = addr[0];
   assign rf_addr_b = addr[1];
   assign pred_we   = busy_q;
   assign pred_sel  = dst_q;
   assign pred_pos  = idx_q;
   assign busy      = busy_q;
   assign done      = done_q;
   assign illegal   = illegal_q;

   // completion is a single-cycle pulse outside the busy window
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // reserved selectors flag once and never launch
   assert_illegal_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> !illegal);
   assert_illegal_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!busy && !done));

   // writes stay below the latched element count
   assert_pos_below_vl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pred_we |-> (VLW'(pred_pos) < vl_q));

   // positions climb by one with a fixed destination
   assert_pos_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_we && $past(pred_we)) |-> (pred_pos == $past(pred_pos) + POSW'(1)));
   assert_dst_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_we && $past(pred_we)) |-> $stable(pred_sel));

   // a scalar source is read from one register throughout
   assert_scalar_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !vec_q[0]) |-> $stable(rf_addr_a));
endmodule

// File: tb/pvcmp_seq_tb.sv
module pvcmp_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int XL   = 4;
   localparam int NR   = 32;
   localparam int VMAX = 16;
   localparam int VW   = 5;
   localparam logic [6:0] BR = 7'b1100011;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [31:0]    instr = '0;
   logic [VW-1:0]  vl = '0;
   logic [NR*VW-1:0] reg_vlen;
   logic [4:0]     rf_addr_a, rf_addr_b;
   logic [XL-1:0]  rf_data_a, rf_data_b;
   logic           pred_we, pred_val, busy, done, illegal;
   logic [4:0]     pred_sel;
   logic [3:0]     pred_pos;

   logic [XL-1:0]   regs [NR];
   logic [VW-1:0]   cfg  [NR];
   logic [VMAX-1:0] pm   [NR];

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rf_data_a = regs[rf_addr_a];
   assign rf_data_b = regs[rf_addr_b];

   always_comb begin
      for (int i = 0; i < NR; i++) reg_vlen[i*VW +: VW] = cfg[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NR; i++) pm[i] <= '0;
      end else if (pred_we) begin
         pm[pred_sel][pred_pos] <= pred_val;
      end
   end

   pvcmp_seq #(.XLEN(XL), .NREG(NR), .VLMAX(VMAX)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .vl(vl),
      .reg_vlen(reg_vlen), .rf_addr_a(rf_addr_a), .rf_data_a(rf_data_a),
      .rf_addr_b(rf_addr_b), .rf_data_b(rf_data_b), .pred_we(pred_we),
      .pred_sel(pred_sel), .pred_pos(pred_pos), .pred_val(pred_val),
      .busy(busy), .done(done), .illegal(illegal)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit ref_cmp(input int f3, input int a, input int b);
      int sa = (a >= 8) ? a - 16 : a;
      int sb = (b >= 8) ? b - 16 : b;
      case (f3)
         0: return a == b;
         1: return a != b;
         4: return sa < sb;
         5: return sa >= sb;
         6: return a < b;
         default: return a >= b;
      endcase
   endfunction

   // launch one instruction and follow it cycle by cycle
   task automatic run_op(input int f3, input int s1, input int s2, input int pd,
                         input int vlen, input logic [6:0] upper, input bit poke);
      int vle = (vlen > VMAX) ? VMAX : vlen;
      bit v1 = (cfg[s1] > 1);
      bit v2 = (cfg[s2] > 1);
      logic [VMAX-1:0] expm = pm[pd];
      @(negedge clk);
      instr = {upper, 5'(s2), 5'(s1), 3'(f3), 5'(pd), BR};
      vl    = VW'(vlen);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < vle; k++) begin
         int aa = v1 ? (s1 + k) % NR : s1;
         int ab = v2 ? (s2 + k) % NR : s2;
         bit ev = ref_cmp(f3, int'(regs[aa]), int'(regs[ab]));
         expm[k] = ev;
         chk(busy === 1'b1, "R6 busy during run", int'(busy), 1);
         chk(pred_we === 1'b1, "R5 write strobe", int'(pred_we), 1);
         chk(int'(pred_pos) == k, "R5 position", int'(pred_pos), k);
         chk(int'(pred_sel) == pd, "R5 destination", int'(pred_sel), pd);
         chk(int'(rf_addr_a) == aa, "R4 address A", int'(rf_addr_a), aa);
         chk(int'(rf_addr_b) == ab, "R4 address B", int'(rf_addr_b), ab);
         chk(pred_val === ev, "R2 compare result", int'(pred_val), int'(ev));
         chk(done === 1'b0, "R6 no early done", int'(done), 0);
         if (poke && k == 1) begin
            // R10: second start during the run, with a reserved selector
            instr = {7'h00, 5'd9, 5'd9, 3'b010, 5'd9, BR};
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(illegal === 1'b0, "R10 start ignored while busy", int'(illegal), 0);
         end else begin
            @(negedge clk);
         end
      end
      chk(busy === 1'b0, "R6 busy cleared", int'(busy), 0);
      chk(done === 1'b1, "R6 done pulse", int'(done), 1);
      chk(pred_we === 1'b0, "R7 no write past vl", int'(pred_we), 0);
      @(negedge clk);
      chk(done === 1'b0, "R6 done one cycle", int'(done), 0);
      chk(pm[pd] == expm, "R7 mask above vl kept", int'(pm[pd]), int'(expm));
   endtask

   // a start that must produce nothing but, optionally, an illegal pulse
   task automatic run_dead(input logic [31:0] w, input bit exp_ill, input string req);
      @(negedge clk);
      instr = w;
      vl    = VW'(8);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(illegal === exp_ill, req, int'(illegal), int'(exp_ill));
      chk(busy === 1'b0, req, int'(busy), 0);
      chk(pred_we === 1'b0, req, int'(pred_we), 0);
      chk(done === 1'b0, req, int'(done), 0);
      @(negedge clk);
      chk(illegal === 1'b0, req, int'(illegal), 0);
      chk(busy === 1'b0, req, int'(busy), 0);
      chk(done === 1'b0, req, int'(done), 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int sels [6] = '{0, 1, 4, 5, 6, 7};
      for (int i = 0; i < NR; i++) begin
         regs[i] = '0;
         cfg[i]  = '0;
      end
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && illegal === 1'b0 && pred_we === 1'b0,
          "R6 reset state", int'({busy, done, illegal, pred_we}), 0);
      rst_n = 1'b1;

      // exhaustive operand pairs through each selector (R2, R4, R5)
      cfg[0]  = VW'(16);
      cfg[16] = VW'(16);
      for (int k = 0; k < 16; k++) begin
         for (int i = 0; i < 16; i++) begin
            regs[i]      = XL'(i);
            regs[16 + i] = XL'((i + k) % 16);
         end
         for (int s = 0; s < 6; s++) run_op(sels[s], 0, 16, (k + s) % NR, 16, 7'h00, 1'b0);
      end

      // scalar A against vector B (R4), scalar with length zero config
      cfg[5] = VW'(1);
      regs[5] = 4'h9;
      run_op(4, 5, 16, 20, 16, 7'h00, 1'b0);
      run_op(6, 6, 16, 21, 16, 7'h00, 1'b0);
      // vector A against scalar B
      run_op(7, 0, 5, 22, 12, 7'h00, 1'b0);

      // partial length over a full mask: bits 5..15 must survive (R7)
      run_op(1, 0, 16, 20, 5, 7'h00, 1'b0);
      // vl = 0 and vl = 1 (R6)
      run_op(0, 0, 16, 21, 0, 7'h00, 1'b0);
      run_op(5, 0, 16, 22, 1, 7'h00, 1'b0);
      // vl above maximum clamps to 16 (R9)
      run_op(6, 0, 16, 23, 20, 7'h00, 1'b0);
      // vector source wraps past the last register (R4)
      cfg[30] = VW'(4);
      regs[30] = 4'hF;
      regs[31] = 4'h1;
      run_op(4, 30, 5, 24, 4, 7'h00, 1'b0);
      // reserved upper bits set to all ones (R8)
      run_op(5, 0, 16, 25, 16, 7'h7F, 1'b0);
      // start while busy (R10)
      run_op(0, 0, 16, 26, 6, 7'h00, 1'b1);

      // reserved selectors (R3) and a foreign opcode (R1)
      run_dead({7'h00, 5'd16, 5'd0, 3'b010, 5'd27, BR}, 1'b1, "R3 selector 010");
      run_dead({7'h00, 5'd16, 5'd0, 3'b011, 5'd27, BR}, 1'b1, "R3 selector 011");
      run_dead({7'h00, 5'd16, 5'd0, 3'b000, 5'd27, 7'b1100111}, 1'b0, "R1 other opcode");
      run_dead({7'h00, 5'd16, 5'd0, 3'b010, 5'd27, 7'b0110011}, 1'b0, "R1 other opcode reserved sel");
      chk(pm[27] == '0, "R1 R3 no bits written", int'(pm[27]), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule